// File: doc/BRIEF.md
# MESIF Snooping Coherence Controller

This block is the coherence controller for one private cache on a shared snooping bus. It keeps the coherence state and the tag of a small direct-mapped set of lines, answers load and store requests from its processor, and places read, read-for-ownership and upgrade requests on the bus. It also watches every bus transaction in the single global order, including its own, and reacts to each one. Line data, bus arbitration and main memory are outside the block. The block only reports whether it supplies data (`snp_data_resp`), whether it asserts the shared line (`snp_shared_out`) and whether it writes a dirty line back (`mem_flush`).

Each line holds one of five stable states: Invalid, Shared, Exclusive, Forward and Modified. It can also hold one of three transient states while a request waits for its turn on the bus: IS (a read miss waits for a fill), IM (a write miss waits for ownership) and SM (a Shared or Forward line waits for an upgrade). A small request machine has two states. In CTL_IDLE it accepts processor requests. In CTL_WAIT it holds one outstanding bus request until that request comes back on the snoop channel with `snp_own` high. That return is the point where the request takes its place in the global order. Named transitions: I→IS and I→IM on a miss; IS→E or IS→F on the own read; IM→M and SM→M on the own request; E→M on a silent store; S/F→SM on a store hit; M/E/F→S on a snooped read; any valid state→I on a snooped read-for-ownership; S/F→I on a snooped upgrade; SM→IM when a snooped upgrade or read-for-ownership takes the copy away.

Bus command codes on `bus_req_cmd` and `snp_cmd`: 0 none, 1 read (BusRd), 2 read-for-ownership (BusRdX), 3 upgrade (BusUpg). The address is split into an index, formed by the low log2(LINES) bits, and a tag, formed by the remaining high bits.

Top module: `mesif_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_req_ready` is high, and `cpu_done`, `bus_req_valid`, `snp_data_resp`, `snp_shared_out` and `mem_flush` are low. A snooped read to any address gets no response.
- R2: A load miss moves the line to IS and drives `bus_req_valid` with command 1 and the missing address. When that request returns with `snp_own` high, the line becomes Exclusive if `snp_shared_in` is low, or Forward if it is high. `cpu_done` pulses in the next cycle.
- R3: A load hit in S, E, F or M pulses `cpu_done` in the next cycle and makes no bus request. A store hit in Exclusive moves the line to Modified with no bus request and pulses `cpu_done` in the next cycle.
- R4: A store hit in Shared or Forward moves the line to SM and requests command 3. The line becomes Modified only when its own upgrade returns, and `cpu_done` follows one cycle later.
- R5: A store miss moves the line to IM and requests command 2. The line becomes Modified when its own request returns.
- R6: On a snooped read (command 1) from another cache that hits a valid copy, `snp_shared_out` is high. A line in Forward or Exclusive also drives `snp_data_resp` and drops to Shared. A line in plain Shared never drives `snp_data_resp`.
- R7: On a snooped read from another cache that hits a Modified line, the controller drives `snp_data_resp` and `mem_flush`, and the line becomes Shared.
- R8: On a snooped read-for-ownership (command 2) from another cache, any valid copy becomes Invalid. Modified also drives `mem_flush` and `snp_data_resp`. Exclusive and Forward drive `snp_data_resp` only.
- R9: A snooped upgrade (command 3) from another cache invalidates a line held in Shared or Forward.
- R10: If an upgrade is pending (SM) and another cache's upgrade or read-for-ownership to the same line is snooped first, the copy is lost. The outstanding request changes from command 3 to command 2, and the line still becomes Modified when that request returns.
- R11: While a request is outstanding, `cpu_req_ready` is low and further processor requests are not accepted. Snoops to a line in IS or IM get no response.
- R12: A miss whose index holds a Modified line with a different tag asserts `mem_flush` in the accepting cycle. Snoops respond only when the stored tag matches.
- R13: In a cycle with `snp_valid` high, `cpu_req_ready` is low. The controller never drives `snp_data_resp` or `snp_shared_out` for its own returning request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Processor line address |
| cpu_req_ready | output | 1 | Request accepted in this cycle when valid |
| cpu_done | output | 1 | One-cycle pulse: the accepted request has completed |
| bus_req_valid | output | 1 | Outstanding bus request |
| bus_req_cmd | output | 2 | Requested command (1 read, 2 read-for-ownership, 3 upgrade) |
| bus_req_addr | output | ADDR_W | Address of the outstanding request |
| snp_valid | input | 1 | A bus transaction is visible in this cycle |
| snp_own | input | 1 | The transaction is this controller's own request |
| snp_cmd | input | 2 | Command of the visible transaction |
| snp_addr | input | ADDR_W | Address of the visible transaction |
| snp_shared_in | input | 1 | Another cache holds the line (used on own read) |
| snp_shared_out | output | 1 | This cache holds a copy of the snooped line |
| snp_data_resp | output | 1 | This cache supplies the data for the snooped request |
| mem_flush | output | 1 | This cache writes a dirty line back to memory |

## Verification
The hardest case to reach is the lost upgrade. A store must hit a Shared line, and another cache's upgrade to the same line must then be placed on the snoop channel while the own upgrade is still outstanding. Only after that may the controller's own request be returned. The bench acts as the serial bus and controls the order of transactions cycle by cycle. It builds the Shared line with a snooped read on a Modified line, issues the store, and returns a foreign upgrade before the own one. It then checks that the outstanding command changes from 3 to 2 and that the later own return still ends in Modified. Eviction of a dirty line is reached the same way, by filling one index with two different tags.

// File: rtl/mesif_pkg.sv
package mesif_pkg;

    typedef enum logic [2:0] {
        L_I, L_S, L_E, L_F, L_M, L_IS, L_IM, L_SM
    } line_st_e;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_RDX  = 2'd2,
        CMD_UPG  = 2'd3
    } bus_cmd_e;

    typedef enum logic {
        CTL_IDLE,
        CTL_WAIT
    } ctl_e;

    // A line owns a usable copy of the data (SM still holds its shared copy)
    function automatic logic has_copy(line_st_e s);
        return (s == L_S) || (s == L_E) || (s == L_F) || (s == L_M) || (s == L_SM);
    endfunction

endpackage

// File: rtl/mesif_line_array.sv
module mesif_line_array
    import mesif_pkg::*;
#(
    parameter int LINES = 8,
    parameter int IDX_W = 3,
    parameter int TAG_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_st_e          wr_st,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_e          a_st,
    output logic [TAG_W-1:0]  a_tag,
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_e          b_st,
    output logic [TAG_W-1:0]  b_tag,
    input  logic [IDX_W-1:0]  c_idx,
    output line_st_e          c_st,
    output logic [TAG_W-1:0]  c_tag
);

    line_st_e         st_q  [LINES];
    logic [TAG_W-1:0] tag_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[g]  <= L_I;
                tag_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                st_q[g]  <= wr_st;
                tag_q[g] <= wr_tag;
            end
        end
    end

    assign a_st  = st_q[a_idx];
    assign a_tag = tag_q[a_idx];
    assign b_st  = st_q[b_idx];
    assign b_tag = tag_q[b_idx];
    assign c_st  = st_q[c_idx];
    assign c_tag = tag_q[c_idx];

endmodule

// File: rtl/mesif_snoop_xlate.sv
module mesif_snoop_xlate
    import mesif_pkg::*;
(
    input  logic     hit,
    input  line_st_e cur,
    input  bus_cmd_e cmd,
    output line_st_e nxt,
    output logic     upd,
    output logic     shared,
    output logic     dresp,
    output logic     flush
);

    always_comb begin
        nxt    = cur;
        upd    = 1'b0;
        shared = 1'b0;
        dresp  = 1'b0;
        flush  = 1'b0;
        if (hit) begin
            upd = 1'b1;
            unique case (cmd)
                CMD_RD: begin
                    shared = 1'b1;
                    unique case (cur)
                        L_M:      begin nxt = L_S; dresp = 1'b1; flush = 1'b1; end
                        L_E, L_F: begin nxt = L_S; dresp = 1'b1; end
                        default:  ;
                    endcase
                end
                CMD_RDX: begin
                    unique case (cur)
                        L_M:      begin nxt = L_I; dresp = 1'b1; flush = 1'b1; end
                        L_E, L_F: begin nxt = L_I; dresp = 1'b1; end
                        L_S:      nxt = L_I;
                        L_SM:     nxt = L_IM;
                        default:  ;
                    endcase
                end
                CMD_UPG: begin
                    unique case (cur)
                        L_S, L_F: nxt = L_I;
                        L_SM:     nxt = L_IM;
                        default:  ;
                    endcase
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mesif_snoop_ctrl.sv
module mesif_snoop_ctrl
    import mesif_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LINES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_req_ready,
    output logic              cpu_done,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              snp_valid,
    input  logic              snp_own,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              snp_shared_in,
    output logic              snp_shared_out,
    output logic              snp_data_resp,
    output logic              mem_flush
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    ctl_e             ctl_q, ctl_d;
    logic [IDX_W-1:0] req_idx_q, req_idx_d;
    logic             done_q, done_d;

    logic [IDX_W-1:0] cpu_idx, snp_idx;
    logic [TAG_W-1:0] cpu_tag, snp_tag;
    line_st_e         c_st, s_st, r_st;
    logic [TAG_W-1:0] c_tag, s_tag, r_tag;

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    line_st_e         wr_st;
    logic [TAG_W-1:0] wr_tag;

    logic             s_hit, c_hit, evict_flush;
    line_st_e         x_nxt;
    logic             x_upd, x_shared, x_dresp, x_flush;

    assign cpu_idx = cpu_req_addr[IDX_W-1:0];
    assign cpu_tag = cpu_req_addr[ADDR_W-1:IDX_W];
    assign snp_idx = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

    mesif_line_array #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_lines (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_st  (wr_st),
        .wr_tag (wr_tag),
        .a_idx  (cpu_idx),
        .a_st   (c_st),
        .a_tag  (c_tag),
        .b_idx  (snp_idx),
        .b_st   (s_st),
        .b_tag  (s_tag),
        .c_idx  (req_idx_q),
        .c_st   (r_st),
        .c_tag  (r_tag)
    );

    // Foreign snoop that finds a usable copy with a matching tag
    assign s_hit = snp_valid && !snp_own && (s_tag == snp_tag) && has_copy(s_st);
    assign c_hit = (c_tag == cpu_tag) &&
                   ((c_st == L_S) || (c_st == L_E) || (c_st == L_F) || (c_st == L_M));

    mesif_snoop_xlate u_xlate (
        .hit    (s_hit),
        .cur    (s_st),
        .cmd    (bus_cmd_e'(snp_cmd)),
        .nxt    (x_nxt),
        .upd    (x_upd),
        .shared (x_shared),
        .dresp  (x_dresp),
        .flush  (x_flush)
    );

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= CTL_IDLE;
            req_idx_q <= '0;
            done_q    <= 1'b0;
        end else begin
            ctl_q     <= ctl_d;
            req_idx_q <= req_idx_d;
            done_q    <= done_d;
        end
    end

    // Next-state and line update process; snoops win over the processor port
    always_comb begin
        ctl_d       = ctl_q;
        req_idx_d   = req_idx_q;
        done_d      = 1'b0;
        wr_en       = 1'b0;
        wr_idx      = cpu_idx;
        wr_st       = c_st;
        wr_tag      = cpu_tag;
        evict_flush = 1'b0;
        if (snp_valid && snp_own) begin
            if (ctl_q == CTL_WAIT) begin
                wr_en  = 1'b1;
                wr_idx = req_idx_q;
                wr_tag = r_tag;
                ctl_d  = CTL_IDLE;
                done_d = 1'b1;
                unique case (r_st)
                    L_IS:       wr_st = snp_shared_in ? L_F : L_E;
                    L_IM, L_SM: wr_st = L_M;
                    default: begin
                        wr_en  = 1'b0;
                        ctl_d  = ctl_q;
                        done_d = 1'b0;
                    end
                endcase
            end
        end else if (snp_valid) begin
            wr_en  = x_upd;
            wr_idx = snp_idx;
            wr_st  = x_nxt;
            wr_tag = s_tag;
        end else if (cpu_req_valid && (ctl_q == CTL_IDLE)) begin
            if (c_hit) begin
                if (!cpu_req_write) begin
                    done_d = 1'b1;
                end else begin
                    unique case (c_st)
                        L_M: done_d = 1'b1;
                        L_E: begin
                            wr_en  = 1'b1;
                            wr_st  = L_M;
                            done_d = 1'b1;
                        end
                        default: begin
                            wr_en     = 1'b1;
                            wr_st     = L_SM;
                            ctl_d     = CTL_WAIT;
                            req_idx_d = cpu_idx;
                        end
                    endcase
                end
            end else begin
                wr_en       = 1'b1;
                wr_st       = cpu_req_write ? L_IM : L_IS;
                ctl_d       = CTL_WAIT;
                req_idx_d   = cpu_idx;
                evict_flush = (c_st == L_M);
            end
        end
    end

    // Output process
    always_comb begin
        cpu_req_ready  = (ctl_q == CTL_IDLE) && !snp_valid;
        cpu_done       = done_q;
        bus_req_valid  = (ctl_q == CTL_WAIT);
        bus_req_cmd    = CMD_NONE;
        if (ctl_q == CTL_WAIT) begin
            unique case (r_st)
                L_IS:    bus_req_cmd = CMD_RD;
                L_IM:    bus_req_cmd = CMD_RDX;
                L_SM:    bus_req_cmd = CMD_UPG;
                default: bus_req_cmd = CMD_NONE;
            endcase
        end
        bus_req_addr   = {r_tag, req_idx_q};
        snp_shared_out = x_shared;
        snp_data_resp  = x_dresp;
        mem_flush      = x_flush | evict_flush;
    end

endmodule

// File: rtl/mesif_snoop_ctrl_chk.sv
module mesif_snoop_ctrl_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_ready,
    input logic              cpu_done,
    input logic              bus_req_valid,
    input logic [1:0]        bus_req_cmd,
    input logic [ADDR_W-1:0] bus_req_addr,
    input logic              snp_valid,
    input logic              snp_own,
    input logic [1:0]        snp_cmd,
    input logic              snp_shared_out,
    input logic              snp_data_resp,
    input logic              mem_flush
);

    AST_PENDING_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> !cpu_req_ready); // R11

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !snp_valid) |=> (bus_req_valid && $stable(bus_req_cmd) && $stable(bus_req_addr))); // R2

    AST_REQ_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> (bus_req_cmd != 2'd0)); // R5

    AST_OWN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_own && bus_req_valid) |=> cpu_done); // R4

    AST_OWN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_own) |-> (!snp_data_resp && !snp_shared_out)); // R13

    AST_SNOOP_BLOCKS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !cpu_req_ready); // R13

    AST_FLUSH_SUPPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !snp_own && mem_flush) |-> snp_data_resp); // R7

    AST_NO_DATA_ON_UPG: assert property (@(posedge clk) disable iff (!rst_n)
        snp_data_resp |-> (snp_valid && (snp_cmd != 2'd3))); // R9

endmodule

bind mesif_snoop_ctrl mesif_snoop_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_req_ready  (cpu_req_ready),
    .cpu_done       (cpu_done),
    .bus_req_valid  (bus_req_valid),
    .bus_req_cmd    (bus_req_cmd),
    .bus_req_addr   (bus_req_addr),
    .snp_valid      (snp_valid),
    .snp_own        (snp_own),
    .snp_cmd        (snp_cmd),
    .snp_shared_out (snp_shared_out),
    .snp_data_resp  (snp_data_resp),
    .mem_flush      (mem_flush)
);

// File: tb/tb_mesif_snoop_ctrl.sv
`timescale 1ns/1ps
module tb_mesif_snoop_ctrl;

    localparam logic [1:0] RD = 2'd1, RDX = 2'd2, UPG = 2'd3;
    localparam logic [7:0] A = 8'h12, B = 8'h1A, C = 8'h05;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [7:0] cpu_req_addr = '0;
    logic       cpu_req_ready, cpu_done, bus_req_valid;
    logic [1:0] bus_req_cmd;
    logic [7:0] bus_req_addr;
    logic       snp_valid = 1'b0, snp_own = 1'b0, snp_shared_in = 1'b0;
    logic [1:0] snp_cmd = '0;
    logic [7:0] snp_addr = '0;
    logic       snp_shared_out, snp_data_resp, mem_flush;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] ex;
        string      tg;
    } item_t;
    item_t expq[$];

    always #4 clk = ~clk;

    mesif_snoop_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_req_ready(cpu_req_ready),
        .cpu_done(cpu_done), .bus_req_valid(bus_req_valid),
        .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
        .snp_valid(snp_valid), .snp_own(snp_own), .snp_cmd(snp_cmd),
        .snp_addr(snp_addr), .snp_shared_in(snp_shared_in),
        .snp_shared_out(snp_shared_out), .snp_data_resp(snp_data_resp),
        .mem_flush(mem_flush)
    );

    // Expected outputs packed as {ready, done, req_valid, req_cmd[1:0], data_resp, flush, shared}
    function automatic logic [7:0] e(input logic rdy, input logic dn, input logic brv,
                                     input logic [1:0] cmd, input logic dr,
                                     input logic fl, input logic sh);
        return {rdy, dn, brv, cmd, dr, fl, sh};
    endfunction

    task automatic drive(input logic cv, input logic cw, input logic [7:0] ca,
                         input logic sv, input logic so, input logic [1:0] sc,
                         input logic [7:0] sa, input logic ssh,
                         input logic [7:0] ex, input string tg);
        item_t it;
        @(negedge clk);
        cpu_req_valid = cv; cpu_req_write = cw; cpu_req_addr = ca;
        snp_valid = sv; snp_own = so; snp_cmd = sc; snp_addr = sa; snp_shared_in = ssh;
        it.ex = ex;
        it.tg = tg;
        expq.push_back(it);
    endtask

    task automatic idle(input logic [7:0] ex, input string tg);
        drive(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, ex, tg);
    endtask

    task automatic cpu(input logic w, input logic [7:0] a, input logic [7:0] ex, input string tg);
        drive(1'b1, w, a, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, ex, tg);
    endtask

    task automatic snp(input logic own, input logic [1:0] c, input logic [7:0] a,
                       input logic sh, input logic [7:0] ex, input string tg);
        drive(1'b0, 1'b0, 8'h00, 1'b1, own, c, a, sh, ex, tg);
    endtask

    // Monitor: compares outputs late in each cycle against the queued expectation
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (expq.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it  = expq.pop_front();
                act = {cpu_req_ready, cpu_done, bus_req_valid, bus_req_cmd,
                       snp_data_resp, mem_flush, snp_shared_out};
                n_chk++;
                if (act !== it.ex) begin
                    n_fail++;
                    $display("FAIL %s: got %b expected %b (rdy,done,req,cmd,dresp,flush,shared)",
                             it.tg, act, it.ex);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(e(1,0,0,0,0,0,0), "R1 reset idle");
        snp(0, RD, A, 0, e(0,0,0,0,0,0,0), "R1 all lines invalid");
        // read miss, no sharers -> E
        cpu(0, A, e(1,0,0,0,0,0,0), "R2 load miss accepted");
        idle(e(0,0,1,RD,0,0,0), "R2 BusRd outstanding");
        cpu(0, A, e(0,0,1,RD,0,0,0), "R11 second request stalled");
        snp(1, RD, A, 0, e(0,0,1,RD,0,0,0), "R13 own read silent");
        idle(e(1,1,0,0,0,0,0), "R2 done after own read");
        // silent E->M
        cpu(1, A, e(1,0,0,0,0,0,0), "R3 store hit E");
        idle(e(1,1,0,0,0,0,0), "R3 done without bus");
        snp(0, RD, A, 0, e(0,0,0,0,1,1,1), "R7 M snoops BusRd flushes");
        snp(0, RD, A, 0, e(0,0,0,0,0,0,1), "R6 plain S no data");
        // upgrade that loses the race
        cpu(1, A, e(1,0,0,0,0,0,0), "R4 store hit S");
        idle(e(0,0,1,UPG,0,0,0), "R4 BusUpg outstanding");
        snp(0, UPG, A, 0, e(0,0,1,UPG,0,0,0), "R10 foreign upgrade first");
        idle(e(0,0,1,RDX,0,0,0), "R10 request becomes BusRdX");
        snp(1, RDX, A, 0, e(0,0,1,RDX,0,0,0), "R10 own BusRdX returns");
        idle(e(1,1,0,0,0,0,0), "R10 done");
        snp(0, RDX, A, 0, e(0,0,0,0,1,1,0), "R8 M snoops BusRdX");
        snp(0, RD, A, 0, e(0,0,0,0,0,0,0), "R8 line now invalid");
        // Forward fill
        cpu(0, C, e(1,0,0,0,0,0,0), "R2 load miss C");
        snp(1, RD, C, 1, e(0,0,1,RD,0,0,0), "R2 own read with sharers");
        idle(e(1,1,0,0,0,0,0), "R2 done F fill");
        snp(0, RD, C, 0, e(0,0,0,0,1,0,1), "R6 F supplies data");
        snp(0, RD, C, 0, e(0,0,0,0,0,0,1), "R6 F dropped to S");
        snp(0, UPG, C, 0, e(0,0,0,0,0,0,0), "R9 upgrade invalidates S");
        snp(0, RD, C, 0, e(0,0,0,0,0,0,0), "R9 line invalid after upgrade");
        // clean upgrade from F
        cpu(0, C, e(1,0,0,0,0,0,0), "R2 reload C");
        snp(1, RD, C, 1, e(0,0,1,RD,0,0,0), "R2 own read F again");
        idle(e(1,1,0,0,0,0,0), "R2 done");
        cpu(1, C, e(1,0,0,0,0,0,0), "R4 store hit F");
        idle(e(0,0,1,UPG,0,0,0), "R4 BusUpg from F");
        snp(1, UPG, C, 0, e(0,0,1,UPG,0,0,0), "R4 own upgrade returns");
        idle(e(1,1,0,0,0,0,0), "R4 done after upgrade");
        snp(0, RD, C, 0, e(0,0,0,0,1,1,1), "R4 line is M");
        // store miss and dirty eviction
        cpu(1, A, e(1,0,0,0,0,0,0), "R5 store miss");
        idle(e(0,0,1,RDX,0,0,0), "R5 BusRdX outstanding");
        snp(1, RDX, A, 0, e(0,0,1,RDX,0,0,0), "R5 own BusRdX");
        idle(e(1,1,0,0,0,0,0), "R5 done");
        cpu(0, B, e(1,0,0,0,0,1,0), "R12 dirty victim flushed");
        snp(1, RD, B, 0, e(0,0,1,RD,0,0,0), "R2 own read B");
        idle(e(1,1,0,0,0,0,0), "R2 done B");
        snp(0, RD, A, 0, e(0,0,0,0,0,0,0), "R12 old tag ignored");
        snp(0, RD, B, 0, e(0,0,0,0,1,0,1), "R6 E supplies and drops");
        // snoop during pending fill
        cpu(0, A, e(1,0,0,0,0,0,0), "R12 clean victim no flush");
        snp(0, RD, A, 0, e(0,0,1,RD,0,0,0), "R11 IS line silent");
        snp(1, RD, A, 1, e(0,0,1,RD,0,0,0), "R2 own read to F");
        idle(e(1,1,0,0,0,0,0), "R2 done");
        cpu(0, A, e(1,0,0,0,0,0,0), "R3 load hit F");
        idle(e(1,1,0,0,0,0,0), "R3 load hit done");
        snp(0, RDX, A, 0, e(0,0,0,0,1,0,0), "R8 F on BusRdX supplies");
        snp(0, RD, A, 0, e(0,0,0,0,0,0,0), "R8 F invalidated");
        idle(e(1,0,0,0,0,0,0), "R1 quiet end");
        @(negedge clk);
        #5;
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule